// File: doc/BRIEF.md
# Indirect Pattern Detector

This block learns the address pattern of an indirect array walk, where a load fetches an index `i` and a later access touches `base + (i << s)`. The block is fed two event streams. Index events carry a load's data together with the id of the load-stream table entry that produced it. Miss events carry cache-miss addresses. A single detector entry at a time follows the miss stream.

After the first index, each miss records one slot of candidate bases, `miss - (idx1 << s)`, for every shift `s` in a parameter list. After the second index, each miss is tested against those stored candidates using `miss - (idx2 << s)`. A hit shows that one base and one shift explain both indices. The block then emits a pattern-found result carrying the table entry id, the base and the shift, and it marks that table entry as enabled.

The search is sequential, one slot per cycle. Slots are visited in the order their misses arrived, and within a slot the shifts are tried in list order. The first hit wins. Back-pressure follows valid/ready rules:
- A transfer happens on a rising edge where both valid and ready are high.
- `idx_ready` is high only while the block is idle.
- `miss_ready` is high only while the block is idle and no index event is offered in the same cycle.
- A result on the found port stays valid and unchanged until `found_ready` takes it.

When a detector entry must be allocated, a free entry is used if one exists; otherwise the victim is chosen round-robin.

Top module: `indirect_pattern_detector`

## Requirements
- R1: An index event is captured only when `idx_read` and `idx_hit` are both 1 and `idx_bytes` (a byte count) is 1, 2, 4 or 8. The index is the low `idx_bytes` bytes of `idx_data`, zero-extended. Any other index event is accepted and has no effect.
- R2: An index event for a table entry that an earlier match has enabled is accepted and has no effect.
- R3: A captured index whose entry id has no detector entry allocates one and stores the value as the first index. That entry becomes the miss tracker, so `tracking` becomes 1. After reset `tracking` is 0.
- R4: While the tracker holds only a first index, each accepted miss fills the next slot with `miss - (idx1 << s)` for every listed shift. Once all SLOTS slots are filled, `tracking` drops to 0.
- R5: A second captured index for the same entry id is stored as the second index and makes that entry the tracker again, so `tracking` becomes 1.
- R6: A third captured index for the same entry id before any match frees the detector entry and sets `tracking` to 0. Later misses produce no result.
- R7: Under a second index, an accepted miss starts a search of one slot per cycle, and `miss_ready` stays 0 throughout. A match in slot k raises `found_valid` after exactly k+1 rising edges following the miss handshake edge.
- R8: The search visits slots in miss-arrival order and, within a slot, shifts in SHIFT_LIST order (element 0 first). The first hit found is reported.
- R9: On a match, `found_entry`, `found_base` and `found_shift` give the entry id, the matching candidate and its shift. The detector entry is freed, `tracking` drops to 0, and the table entry becomes enabled.
- R10: `found_valid` and the found fields hold steady until `found_ready` is 1. While `found_valid` is 1, `idx_ready` and `miss_ready` are 0.
- R11: A search that finds no hit returns the block to idle with the tracker kept, so the next miss is searched again.
- R12: Index events take precedence over misses. `idx_ready` is 1 whenever the block is idle, and `miss_ready` is 0 in any cycle where `idx_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_valid | input | 1 | Index event offered |
| idx_ready | output | 1 | Index event can be taken |
| idx_entry | input | PT_W | Load-stream table entry id |
| idx_data | input | DATA_W | Loaded data |
| idx_bytes | input | BYTES_W | Load size in bytes |
| idx_read | input | 1 | Load is a read |
| idx_hit | input | 1 | Load hit in the cache |
| miss_valid | input | 1 | Miss event offered |
| miss_ready | output | 1 | Miss event can be taken |
| miss_addr | input | ADDR_W | Miss address |
| found_valid | output | 1 | Pattern-found result valid |
| found_ready | input | 1 | Result taken |
| found_entry | output | PT_W | Entry id of the learned pattern |
| found_base | output | ADDR_W | Learned base address |
| found_shift | output | SHIFT_W | Learned shift |
| tracking | output | 1 | A detector entry is following misses |

## Verification
The assertions assume that the upstream holds each offered event stable until it is accepted. They also assume that index events are only ever offered for table entry ids below PT_ENTRIES, so a tracker always points at a live detector entry. The bench drives every event through tasks that wait for ready before releasing valid, and it uses only ids within range. Each scenario starts from reset, so every expected base follows directly from the miss and index values the bench chose, with no state carried over between scenarios.

// File: rtl/ipd_pkg.sv
`timescale 1ns/1ps
package ipd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_REPORT = 2'd2
  } ipd_state_e;
endpackage

// File: rtl/ipd_idx_filter.sv
`timescale 1ns/1ps
module ipd_idx_filter #(
  parameter int DATA_W  = 64,
  parameter int BYTES_W = 4
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [BYTES_W-1:0] bytes,
  input  logic               read,
  input  logic               hit,
  output logic               take,
  output logic [DATA_W-1:0]  index
);
  localparam int NB = DATA_W / 8;

  logic legal;

  always_comb begin
    legal = 1'b0;
    case (32'(bytes))
      1, 2, 4, 8: legal = (32'(bytes) * 8) <= DATA_W;
      default:    legal = 1'b0;
    endcase
  end

  assign take = read && hit && legal;

  // keep only the bytes covered by the load size
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign index[b*8 +: 8] = (32'(bytes) > b) ? data[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/ipd_cand_calc.sv
`timescale 1ns/1ps
module ipd_cand_calc #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int NSHIFT  = 4,
  parameter int SHIFT_W = 3,
  parameter logic [NSHIFT*SHIFT_W-1:0] SHIFT_LIST = '0
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              idx,
  output logic [NSHIFT-1:0][ADDR_W-1:0]  cand
);
  for (genvar k = 0; k < NSHIFT; k++) begin : g_sh
    assign cand[k] = addr - ADDR_W'(idx << SHIFT_LIST[k*SHIFT_W +: SHIFT_W]);
  end
endmodule

// File: rtl/ipd_first_hit.sv
`timescale 1ns/1ps
module ipd_first_hit #(
  parameter int N = 4,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    any = |hits;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) sel = SEL_W'(i);
    end
  end
endmodule

// File: rtl/indirect_pattern_detector.sv
`timescale 1ns/1ps
module indirect_pattern_detector
  import ipd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int BYTES_W     = 4,
  parameter int PT_ENTRIES  = 8,
  parameter int IPD_ENTRIES = 4,
  parameter int SLOTS       = 4,
  parameter int NSHIFT      = 4,
  parameter int SHIFT_W     = 3,
  parameter logic [NSHIFT*SHIFT_W-1:0] SHIFT_LIST = {3'd4, 3'd3, 3'd2, 3'd0},
  localparam int PT_W = $clog2(PT_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_valid,
  output logic               idx_ready,
  input  logic [PT_W-1:0]    idx_entry,
  input  logic [DATA_W-1:0]  idx_data,
  input  logic [BYTES_W-1:0] idx_bytes,
  input  logic               idx_read,
  input  logic               idx_hit,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [ADDR_W-1:0]  miss_addr,
  output logic               found_valid,
  input  logic               found_ready,
  output logic [PT_W-1:0]    found_entry,
  output logic [ADDR_W-1:0]  found_base,
  output logic [SHIFT_W-1:0] found_shift,
  output logic               tracking
);
  localparam int IPD_W  = $clog2(IPD_ENTRIES);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int SEL_W  = $clog2(NSHIFT);

  // detector storage
  logic [IPD_ENTRIES-1:0]                               e_valid;
  logic [IPD_ENTRIES-1:0]                               e_second;
  logic [IPD_ENTRIES-1:0][PT_W-1:0]                     e_tag;
  logic [IPD_ENTRIES-1:0][DATA_W-1:0]                   e_idx1;
  logic [IPD_ENTRIES-1:0][DATA_W-1:0]                   e_idx2;
  logic [IPD_ENTRIES-1:0][CNT_W-1:0]                    e_num;
  logic [IPD_ENTRIES-1:0][SLOTS-1:0][NSHIFT-1:0][ADDR_W-1:0] e_cand;
  logic [PT_ENTRIES-1:0]                                pt_en;

  ipd_state_e          state;
  logic                trk_on;
  logic [IPD_W-1:0]    trk_ptr;
  logic [IPD_W-1:0]    rr_ptr;
  logic [SLOT_W-1:0]   srch_slot;
  logic [ADDR_W-1:0]   srch_addr;
  logic [PT_W-1:0]     fnd_entry_q;
  logic [ADDR_W-1:0]   fnd_base_q;
  logic [SHIFT_W-1:0]  fnd_shift_q;

  // handshakes
  assign idx_ready  = (state == ST_IDLE);
  assign miss_ready = (state == ST_IDLE) && !idx_valid;
  wire idx_fire  = idx_valid && idx_ready;
  wire miss_fire = miss_valid && miss_ready;

  // index filter
  logic              take;
  logic [DATA_W-1:0] idx_val;

  ipd_idx_filter #(.DATA_W(DATA_W), .BYTES_W(BYTES_W)) u_filter (
    .data (idx_data),
    .bytes(idx_bytes),
    .read (idx_read),
    .hit  (idx_hit),
    .take (take),
    .index(idx_val)
  );

  wire capture = idx_fire && take && !pt_en[idx_entry];

  // lookup by table entry id, free entry search
  logic             lk_hit;
  logic [IPD_W-1:0] lk_idx;
  logic             has_free;
  logic [IPD_W-1:0] free_idx;
  logic [IPD_W-1:0] victim;

  always_comb begin
    lk_hit   = 1'b0;
    lk_idx   = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = IPD_ENTRIES - 1; i >= 0; i--) begin
      if (e_valid[i] && (e_tag[i] == idx_entry)) begin
        lk_hit = 1'b1;
        lk_idx = IPD_W'(i);
      end
      if (!e_valid[i]) begin
        has_free = 1'b1;
        free_idx = IPD_W'(i);
      end
    end
  end

  assign victim = has_free ? free_idx : rr_ptr;

  // candidate generation: fill path (idx1) and compare path (idx2)
  logic [NSHIFT-1:0][ADDR_W-1:0] cand_fill;
  logic [NSHIFT-1:0][ADDR_W-1:0] cand_cmp;

  ipd_cand_calc #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSHIFT(NSHIFT),
    .SHIFT_W(SHIFT_W), .SHIFT_LIST(SHIFT_LIST)
  ) u_fill_calc (
    .addr(miss_addr),
    .idx (e_idx1[trk_ptr]),
    .cand(cand_fill)
  );

  ipd_cand_calc #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSHIFT(NSHIFT),
    .SHIFT_W(SHIFT_W), .SHIFT_LIST(SHIFT_LIST)
  ) u_cmp_calc (
    .addr(srch_addr),
    .idx (e_idx2[trk_ptr]),
    .cand(cand_cmp)
  );

  // per-shift compare of the current slot
  logic [NSHIFT-1:0] sh_hits;
  for (genvar k = 0; k < NSHIFT; k++) begin : g_cmp
    assign sh_hits[k] = (e_cand[trk_ptr][srch_slot][k] == cand_cmp[k]);
  end

  logic             hit_any;
  logic [SEL_W-1:0] hit_sel;

  ipd_first_hit #(.N(NSHIFT)) u_pick (
    .hits(sh_hits),
    .any (hit_any),
    .sel (hit_sel)
  );

  wire fill_en = (state == ST_IDLE) && miss_fire && trk_on && !e_second[trk_ptr];
  wire [SLOT_W-1:0] fill_slot = e_num[trk_ptr][SLOT_W-1:0];
  wire last_slot = (CNT_W'(srch_slot) + CNT_W'(1)) == e_num[trk_ptr];

  // candidate storage
  always_ff @(posedge clk) begin
    if (fill_en) e_cand[trk_ptr][fill_slot] <= cand_fill;
  end

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      e_valid     <= '0;
      e_second    <= '0;
      e_tag       <= '0;
      e_idx1      <= '0;
      e_idx2      <= '0;
      e_num       <= '0;
      pt_en       <= '0;
      trk_on      <= 1'b0;
      trk_ptr     <= '0;
      rr_ptr      <= '0;
      srch_slot   <= '0;
      srch_addr   <= '0;
      fnd_entry_q <= '0;
      fnd_base_q  <= '0;
      fnd_shift_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (capture) begin
            if (lk_hit) begin
              if (!e_second[lk_idx]) begin
                e_idx2[lk_idx]   <= idx_val;
                e_second[lk_idx] <= 1'b1;
                trk_on           <= 1'b1;
                trk_ptr          <= lk_idx;
              end else begin
                e_valid[lk_idx] <= 1'b0;
                trk_on          <= 1'b0;
              end
            end else begin
              e_valid[victim]  <= 1'b1;
              e_tag[victim]    <= idx_entry;
              e_idx1[victim]   <= idx_val;
              e_second[victim] <= 1'b0;
              e_num[victim]    <= '0;
              trk_on           <= 1'b1;
              trk_ptr          <= victim;
              if (!has_free) rr_ptr <= rr_ptr + IPD_W'(1);
            end
          end else if (miss_fire && trk_on) begin
            if (!e_second[trk_ptr]) begin
              e_num[trk_ptr] <= e_num[trk_ptr] + CNT_W'(1);
              if (e_num[trk_ptr] + CNT_W'(1) == CNT_W'(SLOTS)) trk_on <= 1'b0;
            end else if (e_num[trk_ptr] != '0) begin
              srch_addr <= miss_addr;
              srch_slot <= '0;
              state     <= ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (hit_any) begin
            fnd_entry_q      <= e_tag[trk_ptr];
            fnd_base_q       <= e_cand[trk_ptr][srch_slot][hit_sel];
            fnd_shift_q      <= SHIFT_LIST[hit_sel*SHIFT_W +: SHIFT_W];
            e_valid[trk_ptr] <= 1'b0;
            pt_en[e_tag[trk_ptr]] <= 1'b1;
            trk_on           <= 1'b0;
            state            <= ST_REPORT;
          end else if (last_slot) begin
            state <= ST_IDLE;
          end else begin
            srch_slot <= srch_slot + SLOT_W'(1);
          end
        end
        ST_REPORT: begin
          if (found_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign found_valid = (state == ST_REPORT);
  assign found_entry = fnd_entry_q;
  assign found_base  = fnd_base_q;
  assign found_shift = fnd_shift_q;
  assign tracking    = trk_on;

  // R3
  alloc_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture && !lk_hit |=> trk_on && e_valid[trk_ptr] && !e_second[trk_ptr]);

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> e_num[trk_ptr] < CNT_W'(SLOTS));

  // R2
  enabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_fire && pt_en[idx_entry] |=> $stable(trk_on) && $stable(trk_ptr));

  // R6
  third_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture && lk_hit && e_second[lk_idx] |=> !trk_on);

  // R7
  search_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SEARCH |-> trk_on && (CNT_W'(srch_slot) < e_num[trk_ptr]));

  // R11
  nomatch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SEARCH && !hit_any && last_slot |=> state == ST_IDLE && trk_on);

  // R9
  found_clears_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found_valid) |-> !tracking);

  // R10
  found_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_valid && !found_ready |=> found_valid && $stable(found_base)
      && $stable(found_shift) && $stable(found_entry));
endmodule

// File: tb/indirect_pattern_detector_bench.sv
`timescale 1ns/1ps
module indirect_pattern_detector_bench;
  localparam int SLOTS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_valid = 1'b0;
  logic        idx_ready;
  logic [2:0]  idx_entry = '0;
  logic [63:0] idx_data = '0;
  logic [3:0]  idx_bytes = '0;
  logic        idx_read = 1'b0;
  logic        idx_hit = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_addr = '0;
  logic        found_valid;
  logic        found_ready = 1'b0;
  logic [2:0]  found_entry;
  logic [31:0] found_base;
  logic [2:0]  found_shift;
  logic        tracking;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  indirect_pattern_detector u_indirect_pattern_detector (
    .clk, .rst_n, .idx_valid, .idx_ready, .idx_entry, .idx_data, .idx_bytes,
    .idx_read, .idx_hit, .miss_valid, .miss_ready, .miss_addr,
    .found_valid, .found_ready, .found_entry, .found_base, .found_shift,
    .tracking
  );

  function automatic int shv(int k);
    case (k)
      0: return 0;
      1: return 2;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] cand(logic [31:0] m, logic [63:0] idx, int s);
    return m - 32'(idx << s);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; idx_valid = 1'b0; miss_valid = 1'b0; found_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic send_idx(int e, logic [63:0] d, int nb, bit rd, bit ht);
    @(negedge clk);
    idx_valid = 1'b1; idx_entry = 3'(e); idx_data = d; idx_bytes = 4'(nb);
    idx_read = rd; idx_hit = ht;
    #1;
    while (!idx_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 idx_valid = 1'b0;
  endtask

  task automatic send_miss(logic [31:0] a);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a;
    #1;
    while (!miss_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 miss_valid = 1'b0;
  endtask

  // count edges after a miss handshake until found_valid; checks busy meanwhile
  task automatic wait_found(output int lat, input bit busy_chk);
    lat = 0;
    while (!found_valid && lat < 20) begin
      @(posedge clk); #1;
      lat++;
      if (busy_chk && !found_valid) chk("R7 busy miss_ready", miss_ready, 0);
    end
  endtask

  task automatic run_match(int e, int k, int si, logic [63:0] d1, logic [63:0] d2,
                           int nb1, int nb2, logic [63:0] x1, logic [63:0] x2);
    logic [31:0] m [SLOTS];
    logic [31:0] base;
    int lat;
    do_reset();
    send_idx(e, d1, nb1, 1, 1);
    chk("R3 tracking after first index", tracking, 1);
    for (int j = 0; j < SLOTS; j++) begin
      m[j] = 32'h0001_0000 * (j + 1) + 32'h100;
      send_miss(m[j]);
    end
    chk("R4 tracking off after slots full", tracking, 0);
    send_idx(e, d2, nb2, 1, 1);
    chk("R5 tracking after second index", tracking, 1);
    base = cand(m[k], x1, shv(si));
    send_miss(base + 32'(x2 << shv(si)));
    wait_found(lat, 1'b1);
    chk("R7 latency", 64'(lat), 64'(k + 1));
    chk("R8 base", found_base, base);
    chk("R9 shift", found_shift, 64'(shv(si)));
    chk("R9 entry", found_entry, 64'(e));
    chk("R10 idx_ready held low", idx_ready, 0);
    chk("R10 miss_ready held low", miss_ready, 0);
    repeat (2) begin @(posedge clk); #1; end
    chk("R10 found held", found_valid, 1);
    chk("R10 base held", found_base, base);
    @(negedge clk); found_ready = 1'b1;
    @(posedge clk); #1 found_ready = 1'b0;
    chk("R9 found released", found_valid, 0);
    chk("R9 tracking off", tracking, 0);
    send_idx(e, 64'd9, 4, 1, 1);
    chk("R2 enabled entry ignored", tracking, 0);
  endtask

  initial begin
    int lat;
    logic [31:0] b;
    do_reset();
    chk("R3 reset tracking", tracking, 0);
    chk("R10 reset found_valid", found_valid, 0);
    chk("R12 reset idx_ready", idx_ready, 1);
    chk("R12 reset miss_ready", miss_ready, 1);

    // R1: size sweep
    for (int nb = 0; nb < 16; nb++) begin
      do_reset();
      send_idx(1, 64'd5, nb, 1, 1);
      chk($sformatf("R1 size %0d", nb), tracking, (nb == 1 || nb == 2 || nb == 4 || nb == 8));
    end
    do_reset();
    send_idx(1, 64'd5, 4, 0, 1);
    chk("R1 write ignored", tracking, 0);
    send_idx(1, 64'd5, 4, 1, 0);
    chk("R1 miss load ignored", tracking, 0);

    // R7 R8 R9: sweep of match slot and shift
    for (int si = 0; si < 4; si++)
      for (int k = 0; k < SLOTS; k++)
        run_match((si * 4 + k) % 8, k, si, 64'd3, 64'd5, 4, 4, 64'd3, 64'd5);

    // R1: zero extension of narrow loads
    run_match(6, 2, 1, 64'hABCD_EF12_3456_7803, 64'h1111_2222_3333_0005, 1, 2, 64'd3, 64'd5);
    run_match(7, 1, 3, 64'h0000_0000_0000_0103, 64'h0000_0000_0000_0005, 8, 8,
              64'h103, 64'd5);

    // R6: third index drops the detector entry
    do_reset();
    send_idx(2, 64'd3, 4, 1, 1);
    send_miss(32'h0002_0000);
    send_idx(2, 64'd5, 4, 1, 1);
    send_idx(2, 64'd6, 4, 1, 1);
    chk("R6 tracking off", tracking, 0);
    send_miss(cand(32'h0002_0000, 64'd3, 0) + 32'd5);
    repeat (SLOTS + 2) begin @(posedge clk); #1; end
    chk("R6 no result", found_valid, 0);

    // R11: no match keeps tracker, next miss searched
    do_reset();
    send_idx(4, 64'd3, 4, 1, 1);
    send_miss(32'h0003_0000);
    send_miss(32'h0004_0000);
    send_idx(4, 64'd5, 4, 1, 1);
    send_miss(32'h7777_0000);
    @(posedge clk); #1;
    chk("R11 busy in search", miss_ready, 0);
    @(posedge clk); #1;
    chk("R11 idle after search", miss_ready, 1);
    chk("R11 no result", found_valid, 0);
    chk("R11 tracker kept", tracking, 1);
    b = cand(32'h0004_0000, 64'd3, 3);
    send_miss(b + 32'(64'd5 << 3));
    wait_found(lat, 1'b0);
    chk("R11 latency second search", 64'(lat), 2);
    chk("R11 base", found_base, b);
    @(negedge clk); found_ready = 1'b1;
    @(posedge clk); #1 found_ready = 1'b0;

    // R8: ties resolve to slot 0 and first listed shift
    do_reset();
    send_idx(3, 64'd7, 4, 1, 1);
    for (int j = 0; j < SLOTS; j++) send_miss(32'h0000_5000);
    send_idx(3, 64'd7, 4, 1, 1);
    send_miss(32'h0000_5000);
    wait_found(lat, 1'b0);
    chk("R8 tie latency", 64'(lat), 1);
    chk("R8 tie shift", found_shift, 0);
    chk("R8 tie base", found_base, 32'h0000_5000 - 32'd7);

    // R12: index precedence
    do_reset();
    @(negedge clk);
    idx_valid = 1'b1; idx_entry = 3'd1; idx_data = 64'd3; idx_bytes = 4'd4;
    idx_read = 1'b1; idx_hit = 1'b1;
    miss_valid = 1'b1; miss_addr = 32'h100;
    #1;
    chk("R12 miss_ready low with idx_valid", miss_ready, 0);
    chk("R12 idx_ready high", idx_ready, 1);
    @(posedge clk); #1 idx_valid = 1'b0;
    #1;
    chk("R12 miss_ready after index", miss_ready, 1);
    @(posedge clk); #1 miss_valid = 1'b0;
    chk("R12 index was taken", tracking, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule